// File: doc/BRIEF.md
# Paged Bus Window Bridge

This bridge lets a host with a narrow, 16-bit offset space reach any location of a 32-bit Wishbone address space. The host sees two regions. The lower half of its offset space, with offset bit 15 clear, holds a single page register. The upper half, with bit 15 set, is a 32 KiB data window. The page register keeps the upper 17 bits of a full address. An access in the window becomes one Wishbone classic cycle. Its address takes the stored page in bits 31:15 and the host offset's bits 14:0.

Firmware sets the page first and then reads or writes through the window, as often as needed. Only one downstream cycle exists at any time. A slave that never acknowledges cannot hang the host: after a bounded wait the bridge ends the cycle itself and answers with all-ones data.

The host side uses two valid/ready channels. A request is taken on a cycle where `host_req_valid` and `host_req_ready` are both high. The bridge holds `host_req_ready` low from acceptance until the host has taken the response. The response stays valid, with constant data, until the host raises `host_rsp_ready`. The host may hold back `host_rsp_ready` for as long as it likes.

Top module: `bwb_bridge`

## Requirements
- R1: After reset the stored page is zero, `host_req_ready` is high, and `host_rsp_valid`, `wb_cyc_o` and `wb_stb_o` are low.
- R2: A request with offset bit 15 clear addresses the page register, whatever the other offset bits are. A write stores `host_req_wdata[31:15]`. A read returns the stored page in bits 31:15 and zero in bits 14:0. A page write answers with data 0 one cycle after acceptance, and starts no bus cycle.
- R3: A request with offset bit 15 set raises `wb_cyc_o` and `wb_stb_o` together in the cycle after acceptance. `wb_adr_o` is {stored page, offset[14:0]}.
- R4: During a window cycle, `wb_we_o`, `wb_dat_o` and `wb_sel_o` equal the request's write flag, write data and byte selects.
- R5: While a window cycle waits for `wb_ack_i`, all Wishbone outputs hold their values, and no response is presented.
- R6: When `wb_ack_i` is sampled high during a window cycle, the cycle ends at that edge. The response then carries `wb_dat_i` unchanged for a read, or 0 for a write.
- R7: If no acknowledge is sampled within 255 cycles of `wb_cyc_o`, the cycle ends and the response carries 0xFFFFFFFF. An acknowledge sampled on the 255th cycle still counts.
- R8: `host_rsp_valid` and `host_rsp_rdata` hold until a cycle where `host_rsp_ready` is high. `host_req_ready` returns in the following cycle.
- R9: `host_req_ready` is low from the cycle after acceptance until the response has been taken, so at most one request is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| host_req_valid | input | 1 | host request valid |
| host_req_ready | output | 1 | bridge can take a request |
| host_req_we | input | 1 | 1 = write, 0 = read |
| host_req_offs | input | 16 | host offset; bit 15 selects the window |
| host_req_wdata | input | 32 | write data |
| host_req_sel | input | 4 | byte selects for window writes |
| host_rsp_valid | output | 1 | response valid |
| host_rsp_ready | input | 1 | host takes the response |
| host_rsp_rdata | output | 32 | response data |
| wb_cyc_o | output | 1 | Wishbone cycle |
| wb_stb_o | output | 1 | Wishbone strobe |
| wb_we_o | output | 1 | Wishbone write enable |
| wb_adr_o | output | 32 | Wishbone byte address |
| wb_dat_o | output | 32 | Wishbone write data |
| wb_sel_o | output | 4 | Wishbone byte selects |
| wb_ack_i | input | 1 | Wishbone acknowledge |
| wb_dat_i | input | 32 | Wishbone read data |

## Verification
The assertions take for granted that the slave raises `wb_ack_i` only while `wb_cyc_o` is high, and for one cycle per transfer. The stability and timeout properties assume the slave never acknowledges a cycle the bridge has already dropped. The bench slave follows these rules. It counts the cycles of `wb_cyc_o` and raises the acknowledge after a chosen latency, or never. It clears the acknowledge as soon as the cycle ends, so latencies of 254 and 255 exercise both sides of the timeout limit without leaving a stray acknowledge.

// File: rtl/bwb_pkg.sv
package bwb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUS  = 2'd1,
    ST_RESP = 2'd2
  } bwb_state_e;
endpackage

// File: rtl/bwb_page_reg.sv
module bwb_page_reg #(
  parameter int PAGE_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_page,
  output logic [PAGE_W-1:0] page
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) page <= '0;
    else if (wr_en) page <= wr_page;
  end
endmodule

// File: rtl/bwb_timeout.sv
module bwb_timeout #(
  parameter int LIMIT = 255
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic ack,
  output logic expired
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (busy && !ack) cnt <= cnt + 1'b1;
    else cnt <= '0;
  end

  assign expired = busy && !ack && (cnt == LAST);
endmodule

// File: rtl/bwb_seq.sv
module bwb_seq
  import bwb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFFS_W = 15,
  localparam int PAGE_W = ADDR_W - OFFS_W,
  localparam int SEL_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [OFFS_W:0]   req_offs,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [SEL_W-1:0]  req_sel,
  input  logic              rsp_ready,
  input  logic [PAGE_W-1:0] page,
  input  logic              ack,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              expired,
  output bwb_state_e        state,
  output logic              page_wr,
  output logic [PAGE_W-1:0] page_wdata,
  output logic [ADDR_W-1:0] bus_adr,
  output logic              bus_we,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [SEL_W-1:0]  bus_sel,
  output logic [DATA_W-1:0] rsp_data
);
  logic accept;
  logic in_window;

  assign accept     = (state == ST_IDLE) && req_valid;
  assign in_window  = req_offs[OFFS_W];
  assign page_wr    = accept && !in_window && req_we;
  assign page_wdata = req_wdata[DATA_W-1 -: PAGE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bus_adr   <= '0;
      bus_we    <= 1'b0;
      bus_wdata <= '0;
      bus_sel   <= '0;
      rsp_data  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (in_window) begin
              state     <= ST_BUS;
              bus_adr   <= {page, req_offs[OFFS_W-1:0]};
              bus_we    <= req_we;
              bus_wdata <= req_wdata;
              bus_sel   <= req_sel;
            end else begin
              state    <= ST_RESP;
              rsp_data <= req_we ? '0 : {page, {OFFS_W{1'b0}}};
            end
          end
        end
        ST_BUS: begin
          if (ack) begin
            state    <= ST_RESP;
            rsp_data <= bus_we ? '0 : bus_rdata;
          end else if (expired) begin
            state    <= ST_RESP;
            rsp_data <= '1;
          end
        end
        ST_RESP: begin
          if (rsp_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bwb_bridge.sv
module bwb_bridge
  import bwb_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int OFFS_W  = 15,
  parameter int TIMEOUT = 255,
  localparam int PAGE_W = ADDR_W - OFFS_W,
  localparam int SEL_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req_valid,
  output logic              host_req_ready,
  input  logic              host_req_we,
  input  logic [OFFS_W:0]   host_req_offs,
  input  logic [DATA_W-1:0] host_req_wdata,
  input  logic [SEL_W-1:0]  host_req_sel,
  output logic              host_rsp_valid,
  input  logic              host_rsp_ready,
  output logic [DATA_W-1:0] host_rsp_rdata,
  output logic              wb_cyc_o,
  output logic              wb_stb_o,
  output logic              wb_we_o,
  output logic [ADDR_W-1:0] wb_adr_o,
  output logic [DATA_W-1:0] wb_dat_o,
  output logic [SEL_W-1:0]  wb_sel_o,
  input  logic              wb_ack_i,
  input  logic [DATA_W-1:0] wb_dat_i
);
  bwb_state_e        state;
  logic              page_wr;
  logic [PAGE_W-1:0] page_wdata;
  logic [PAGE_W-1:0] page;
  logic              expired;
  logic              on_bus;

  assign on_bus = (state == ST_BUS);

  bwb_page_reg #(.PAGE_W(PAGE_W)) u_page (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (page_wr),
    .wr_page (page_wdata),
    .page    (page)
  );

  bwb_timeout #(.LIMIT(TIMEOUT)) u_tmo (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (on_bus),
    .ack     (wb_ack_i),
    .expired (expired)
  );

  bwb_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFS_W(OFFS_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (host_req_valid),
    .req_we     (host_req_we),
    .req_offs   (host_req_offs),
    .req_wdata  (host_req_wdata),
    .req_sel    (host_req_sel),
    .rsp_ready  (host_rsp_ready),
    .page       (page),
    .ack        (wb_ack_i),
    .bus_rdata  (wb_dat_i),
    .expired    (expired),
    .state      (state),
    .page_wr    (page_wr),
    .page_wdata (page_wdata),
    .bus_adr    (wb_adr_o),
    .bus_we     (wb_we_o),
    .bus_wdata  (wb_dat_o),
    .bus_sel    (wb_sel_o),
    .rsp_data   (host_rsp_rdata)
  );

  assign host_req_ready = (state == ST_IDLE);
  assign host_rsp_valid = (state == ST_RESP);
  assign wb_cyc_o       = on_bus;
  assign wb_stb_o       = on_bus;
endmodule

// File: rtl/bwb_bridge_chk.sv
module bwb_bridge_chk #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int TIMEOUT = 255
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_req_ready,
  input logic              host_rsp_valid,
  input logic              host_rsp_ready,
  input logic [DATA_W-1:0] host_rsp_rdata,
  input logic              wb_cyc_o,
  input logic              wb_stb_o,
  input logic              wb_we_o,
  input logic [ADDR_W-1:0] wb_adr_o,
  input logic [DATA_W-1:0] wb_dat_o,
  input logic              wb_ack_i
);
  logic [15:0] cyc_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc_len <= '0;
    else if (wb_cyc_o) cyc_len <= cyc_len + 1'b1;
    else cyc_len <= '0;
  end

  assert_cyc_stb_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cyc_o == wb_stb_o);

  assert_one_in_flight_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc_o || host_rsp_valid) |-> !host_req_ready);

  assert_bus_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc_o && !wb_ack_i && $past(wb_cyc_o) && !$past(wb_ack_i))
      |-> ($stable(wb_adr_o) && $stable(wb_we_o) && $stable(wb_dat_o) && !host_rsp_valid));

  assert_ack_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc_o && wb_ack_i) |=> (!wb_cyc_o && host_rsp_valid));

  assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rsp_valid && !host_rsp_ready) |=> (host_rsp_valid && $stable(host_rsp_rdata)));

  assert_bounded_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cyc_o |-> (cyc_len < 16'(TIMEOUT)));
endmodule

bind bwb_bridge bwb_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIMEOUT(TIMEOUT)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .host_req_ready (host_req_ready),
  .host_rsp_valid (host_rsp_valid),
  .host_rsp_ready (host_rsp_ready),
  .host_rsp_rdata (host_rsp_rdata),
  .wb_cyc_o       (wb_cyc_o),
  .wb_stb_o       (wb_stb_o),
  .wb_we_o        (wb_we_o),
  .wb_adr_o       (wb_adr_o),
  .wb_dat_o       (wb_dat_o),
  .wb_ack_i       (wb_ack_i)
);

// File: tb/bwb_bridge_test.sv
`timescale 1ns/100ps
module bwb_bridge_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req_valid = 1'b0;
  logic        host_req_ready;
  logic        host_req_we = 1'b0;
  logic [15:0] host_req_offs = '0;
  logic [31:0] host_req_wdata = '0;
  logic [3:0]  host_req_sel = '0;
  logic        host_rsp_valid;
  logic        host_rsp_ready = 1'b0;
  logic [31:0] host_rsp_rdata;
  logic        wb_cyc_o, wb_stb_o, wb_we_o;
  logic [31:0] wb_adr_o, wb_dat_o;
  logic [3:0]  wb_sel_o;
  logic        wb_ack_i = 1'b0;
  logic [31:0] wb_dat_i = '0;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bwb_bridge uut (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // bench slave
  int lat = 0;
  int scnt = 0;
  logic [31:0] smem [logic [31:0]];

  function automatic logic [31:0] slave_data(input logic [31:0] a);
    if (smem.exists(a)) return smem[a];
    return a ^ 32'h5A5A_C3C3;
  endfunction

  always begin
    @(posedge clk);
    #1;
    if (!wb_cyc_o) begin
      wb_ack_i = 1'b0;
      scnt = 0;
    end else if (wb_ack_i) begin
      wb_ack_i = 1'b0;
    end else begin
      if (scnt == lat) begin
        wb_ack_i = 1'b1;
        wb_dat_i = slave_data(wb_adr_o);
        if (wb_we_o) smem[wb_adr_o] = wb_dat_o;
      end
      scnt++;
    end
  end

  // behavioural reference model: 0 idle, 1 bus, 2 response
  int m_st = 0;
  logic [16:0] m_page = '0;
  logic [31:0] m_adr, m_wd, m_rd;
  logic        m_we;
  logic [3:0]  m_sel;
  int m_wait = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_page = '0; m_rd = '0; m_wait = 0;
    end else begin
      case (m_st)
        0: if (host_req_valid) begin
          if (host_req_offs[15]) begin
            m_st = 1; m_wait = 0;
            m_adr = {m_page, host_req_offs[14:0]};
            m_we = host_req_we; m_wd = host_req_wdata; m_sel = host_req_sel;
          end else begin
            m_st = 2;
            if (host_req_we) begin
              m_page = host_req_wdata[31:15];
              m_rd = 32'h0;
            end else m_rd = {m_page, 15'h0};
          end
        end
        1: begin
          m_wait++;
          if (wb_ack_i) begin
            m_st = 2; m_rd = m_we ? 32'h0 : wb_dat_i;
          end else if (m_wait == 255) begin
            m_st = 2; m_rd = 32'hFFFF_FFFF;
          end
        end
        default: if (host_rsp_ready) m_st = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(host_req_ready == (m_st == 0), "R9 req_ready", 32'(host_req_ready), 32'(m_st == 0));
      check(host_rsp_valid == (m_st == 2), "R8 rsp_valid", 32'(host_rsp_valid), 32'(m_st == 2));
      check(wb_cyc_o == (m_st == 1) && wb_stb_o == (m_st == 1), "R5 cyc/stb", 32'(wb_cyc_o), 32'(m_st == 1));
      if (m_st == 2) check(host_rsp_rdata == m_rd, "R6 rsp_rdata", host_rsp_rdata, m_rd);
      if (m_st == 1) begin
        check(wb_adr_o == m_adr, "R3 adr", wb_adr_o, m_adr);
        check(wb_we_o == m_we, "R4 we", 32'(wb_we_o), 32'(m_we));
        check(wb_dat_o == m_wd, "R4 dat", wb_dat_o, m_wd);
        check(wb_sel_o == m_sel, "R4 sel", 32'(wb_sel_o), 32'(m_sel));
      end
    end
  end

  logic [31:0] got;
  int cyc_seen;

  task automatic access(input bit we, input logic [15:0] offs, input logic [31:0] wd,
                        input logic [3:0] sel, input int hold);
    bit r;
    @(posedge clk); #1;
    host_req_valid = 1'b1; host_req_we = we; host_req_offs = offs;
    host_req_wdata = wd; host_req_sel = sel;
    do begin
      @(negedge clk); r = host_req_ready;
      @(posedge clk); #1;
    end while (!r);
    host_req_valid = 1'b0;
    cyc_seen = 0;
    do begin
      @(negedge clk);
      if (wb_cyc_o) cyc_seen++;
    end while (!host_rsp_valid);
    for (int i = 0; i < hold; i++) @(negedge clk);
    got = host_rsp_rdata;
    @(posedge clk); #1;
    host_rsp_ready = 1'b1;
    @(posedge clk); #1;
    host_rsp_ready = 1'b0;
  endtask

  initial begin
    #200000;
    check(0, "watchdog", 32'h0, 32'h1);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(host_req_ready === 1'b1, "R1 ready after reset", 32'(host_req_ready), 32'h1);
    check(host_rsp_valid === 1'b0 && wb_cyc_o === 1'b0 && wb_stb_o === 1'b0,
          "R1 idle after reset", 32'(wb_cyc_o), 32'h0);
    access(0, 16'h0000, '0, 4'h0, 0);
    check(got == 32'h0, "R1 page resets to zero", got, 32'h0);

    // R2 page write masking, readback, alias
    access(1, 16'h0000, 32'h3080_1234, 4'hF, 0);
    check(got == 32'h0, "R2 page write response", got, 32'h0);
    check(cyc_seen == 0, "R2 page write no bus cycle", 32'(cyc_seen), 32'h0);
    access(0, 16'h0000, '0, 4'h0, 0);
    check(got == 32'h3080_0000, "R2 page readback", got, 32'h3080_0000);
    access(1, 16'h1234, 32'h3303_9FFF, 4'hF, 0);
    access(0, 16'h7FFC, '0, 4'h0, 0);
    check(got == 32'h3303_8000, "R2 alias page access", got, 32'h3303_8000);

    // R3 R4 R6 window write then read back, latency 0 and 3
    lat = 0;
    access(1, 16'h8010, 32'hDEAD_BEEF, 4'h5, 0);
    check(got == 32'h0, "R6 write response zero", got, 32'h0);
    check(cyc_seen == 1, "R3 single-cycle bus", 32'(cyc_seen), 32'h1);
    lat = 3;
    access(0, 16'h8010, '0, 4'hF, 2);
    check(got == 32'hDEAD_BEEF, "R6 read data passthrough", got, 32'hDEAD_BEEF);
    check(cyc_seen == 4, "R5 held until ack", 32'(cyc_seen), 32'h4);
    access(0, 16'hFFFC, '0, 4'hF, 0);
    check(got == (32'h3303_FFFC ^ 32'h5A5A_C3C3), "R3 top of window", got, 32'h3303_FFFC ^ 32'h5A5A_C3C3);

    // R7 acknowledge on last allowed cycle, then timeout
    lat = 254;
    access(0, 16'h8100, '0, 4'hF, 0);
    check(got == (32'h3303_8100 ^ 32'h5A5A_C3C3), "R7 ack on cycle 255", got, 32'h3303_8100 ^ 32'h5A5A_C3C3);
    lat = 255;
    access(0, 16'h8200, '0, 4'hF, 0);
    check(got == 32'hFFFF_FFFF, "R7 timeout data", got, 32'hFFFF_FFFF);
    check(cyc_seen == 255, "R7 timeout length", 32'(cyc_seen), 32'd255);
    lat = -1;
    access(1, 16'h8300, 32'h1111_2222, 4'hF, 1);
    check(got == 32'hFFFF_FFFF, "R7 write timeout data", got, 32'hFFFF_FFFF);

    // R8 R9 long response hold, back-to-back requests
    lat = 1;
    access(0, 16'h8010, '0, 4'hF, 7);
    check(got == 32'hDEAD_BEEF, "R8 held response data", got, 32'hDEAD_BEEF);
    access(1, 16'h0000, 32'h0000_7FFF, 4'hF, 0);
    access(0, 16'h0000, '0, 4'h0, 0);
    check(got == 32'h0, "R2 low bits discarded", got, 32'h0);

    repeat (5) @(posedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule